// File: doc/BRIEF.md
# Flash Burst Read Sequencer

This block sits on the read side of a memory-mapped data port in front of a flash array. A requester presents a start word address and a burst count. When the block is idle it accepts the command and then returns one 32-bit word per cycle after a fixed array latency. It holds off further commands with `waitReq` until the burst has ended.

The burst type is fixed at elaboration. In incrementing mode the word addresses step by one from the start address and roll over at the top of the address space. Bursts of 1 to 128 words are allowed. In wrapping mode the burst length is fixed at 2 or 4 words. The address walks upward from an unaligned start inside the aligned window of that length and wraps back to the window's lower boundary.

Words at addresses beyond the usable range, or in a protected sector, come back as all ones and mark the read as failed. A two-bit busy field and a read-success bit report the state of the burst. The array is a synchronous model with fixed latency whose contents are computed from the address.

Top module: `flash_burst_seq`

## Requirements
- R1: A command is accepted on a rising edge where `rdReq` is high and `waitReq` is low. `waitReq` is high from the accepting edge until the edge that ends the cycle carrying the final word, or the single reject cycle. A request that is presented while `waitReq` is high is ignored and does not disturb the burst in progress.
- R2: In incrementing mode (`WRAP_MODE`=0), word k of a burst reads address (start + k) mod 2^ADDR_W. Counts from 1 to 128 are accepted, and exactly that many words are returned.
- R3: In wrapping mode (`WRAP_MODE`=1, length L = `WRAP_LEN`), word k reads (start with its low log2(L) bits cleared) + ((start + k) mod L). For example, start 2 with L=4 gives 2,3,0,1, and start 1 with L=2 gives 1,0.
- R4: A count of 0, a count above 128, or a count other than L in wrapping mode is rejected. The reject returns no word, holds `waitReq` and busy for exactly one cycle, and leaves `readOk` at 0.
- R5: For a good address a, the returned word is {a ^ 16'hC0DE, a}, with a zero-extended to 16 bits in both halves. The first `rdValid` appears in the cycle after the LAT-th rising edge following acceptance (LAT=2). The following words come on consecutive cycles.
- R6: An address at or above 896, or one whose sector `a[9:8]` has its bit set in `protMask`, returns 32'hFFFFFFFF.
- R7: `busyState` reads 2'b11 while a command is being served and 2'b00 from the edge after the final word or the reject.
- R8: At the end of each burst `readOk` becomes 1 if every word of the burst was good, and 0 otherwise.
- R9: After reset `waitReq`, `rdValid`, `readOk` and `busyState` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read command request |
| rdAddr | input | ADDR_W | Start word address |
| rdCount | input | CNT_W | Burst length in words |
| protMask | input | 2^SECT_W | Per-sector read protection |
| waitReq | output | 1 | Command hold-off, high while busy |
| rdValid | output | 1 | Returned word valid |
| rdData | output | 32 | Returned word |
| busyState | output | 2 | 2'b00 idle, 2'b11 reading |
| readOk | output | 1 | Last burst's success flag |

## Verification
On every cycle, the assertions check that a returned word is only seen while busy, that a reject never carries data, that busy is not dropped while more than one word is still due, and that busy ends only after a final word. They also check that consecutive issued addresses step by one within the incrementing space or within the wrap window. The bench scenarios are needed to show the absolute values: the data pattern, the all-ones substitution for illegal and protected words, the first-word latency, the wrap order from a given start, and the success flag after bursts that mix good and bad words.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic load;
    logic issue;
  } seqStrobe_t;

  function automatic logic [WORD_W-1:0] patWord(input logic [15:0] a);
    return {a ^ 16'hC0DE, a};
  endfunction
endpackage

// File: rtl/flash_seq_array.sv
module flash_seq_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LEGAL_WORDS = 896,
  parameter int SECT_W      = 2,
  parameter int LAT         = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    issue,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [(1<<SECT_W)-1:0]  protMask,
  output logic                    outValid,
  output logic [WORD_W-1:0]       outData,
  output logic                    outBad
);
  localparam logic [ADDR_W:0] LEGAL_LIM = LEGAL_WORDS[ADDR_W:0];

  logic              isBad;
  logic [WORD_W-1:0] rawWord;
  logic [LAT-1:0]             vPipe;
  logic [LAT-1:0]             bPipe;
  logic [LAT-1:0][WORD_W-1:0] dPipe;

  always_comb begin
    isBad   = ({1'b0, addr} >= LEGAL_LIM) || protMask[addr[ADDR_W-1 -: SECT_W]];
    rawWord = isBad ? '1 : patWord(16'(addr));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe <= '0;
    end else begin
      vPipe[0] <= issue;
      for (int i = 1; i < LAT; i++) vPipe[i] <= vPipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dPipe[0] <= rawWord;
    bPipe[0] <= isBad;
    for (int i = 1; i < LAT; i++) begin
      dPipe[i] <= dPipe[i-1];
      bPipe[i] <= bPipe[i-1];
    end
  end

  assign outValid = vPipe[LAT-1];
  assign outData  = dPipe[LAT-1];
  assign outBad   = bPipe[LAT-1];
endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LEGAL_WORDS = 896,
  parameter int SECT_W      = 2,
  parameter int LAT         = 2,
  parameter bit WRAP_MODE   = 1'b0,
  parameter int WRAP_LEN    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strb,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [(1<<SECT_W)-1:0]  protMask,
  output logic                    rdValid,
  output logic [WORD_W-1:0]       rdData,
  output logic                    wordBad
);
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] arrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      offset   <= '0;
    end else if (strb.load) begin
      baseAddr <= rdAddr;
      offset   <= '0;
    end else if (strb.issue) begin
      offset <= offset + 1'b1;
    end
  end

  generate
    if (WRAP_MODE) begin : g_wrap
      localparam int LW = $clog2(WRAP_LEN);
      localparam logic [ADDR_W-1:0] WMASK = ADDR_W'(WRAP_LEN - 1);
      assign arrAddr = (baseAddr & ~WMASK) | ((baseAddr + offset) & WMASK);

      // R3
      wrap_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.issue && $past(strb.issue)) |->
          ((arrAddr[ADDR_W-1:LW] == $past(arrAddr[ADDR_W-1:LW])) &&
           (arrAddr[LW-1:0] == $past(arrAddr[LW-1:0]) + 1'b1)));
    end else begin : g_incr
      assign arrAddr = baseAddr + offset;

      // R2
      incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.issue && $past(strb.issue)) |-> (arrAddr == $past(arrAddr) + 1'b1));
    end
  endgenerate

  flash_seq_array #(
    .ADDR_W(ADDR_W), .LEGAL_WORDS(LEGAL_WORDS), .SECT_W(SECT_W), .LAT(LAT)
  ) uArray (
    .clk(clk), .rstN(rstN), .issue(strb.issue), .addr(arrAddr),
    .protMask(protMask), .outValid(rdValid), .outData(rdData), .outBad(wordBad)
  );
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_BURST = 128,
  parameter bit WRAP_MODE = 1'b0,
  parameter int WRAP_LEN  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic [CNT_W-1:0] rdCount,
  input  logic             rdValid,
  input  logic             wordBad,
  output seqStrobe_t       strb,
  output logic             waitReq,
  output logic [1:0]       busyState,
  output logic             readOk
);
  localparam logic [CNT_W-1:0] MAXC  = CNT_W'(MAX_BURST);
  localparam logic [CNT_W-1:0] WLENC = CNT_W'(WRAP_LEN);

  typedef enum logic {S_IDLE, S_READ} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] issueLeft;
  logic [CNT_W-1:0] retLeft;
  logic             badCmd;
  logic             errAcc;
  logic             accept;
  logic             cmdOk;
  logic             finish;

  always_comb begin
    accept     = rdReq && (state == S_IDLE);
    cmdOk      = (rdCount != '0) && (rdCount <= MAXC) &&
                 ((WRAP_MODE == 1'b0) || (rdCount == WLENC));
    strb.load  = accept;
    strb.issue = (state == S_READ) && (issueLeft != '0);
    finish     = (state == S_READ) && (badCmd || (rdValid && (retLeft == CNT_W'(1))));
    waitReq    = (state == S_READ);
    busyState  = (state == S_READ) ? 2'b11 : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      issueLeft <= '0;
      retLeft   <= '0;
      badCmd    <= 1'b0;
      errAcc    <= 1'b0;
      readOk    <= 1'b0;
    end else if (state == S_IDLE) begin
      if (accept) begin
        state  <= S_READ;
        errAcc <= 1'b0;
        badCmd <= !cmdOk;
        issueLeft <= cmdOk ? rdCount : '0;
        retLeft   <= cmdOk ? rdCount : '0;
      end
    end else begin
      if (strb.issue) issueLeft <= issueLeft - 1'b1;
      if (rdValid) begin
        retLeft <= retLeft - 1'b1;
        errAcc  <= errAcc | wordBad;
      end
      if (finish) begin
        state  <= S_IDLE;
        readOk <= !badCmd && !errAcc && !(rdValid && wordBad);
      end
    end
  end

  // R1
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (state == S_READ));

  // R4
  reject_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && badCmd) |-> (!rdValid && (issueLeft == '0)));

  // R1
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && (retLeft[CNT_W-1:1] != '0)) |=> (state == S_READ));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(waitReq) |-> ($past(badCmd) || $past(rdValid)));
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LEGAL_WORDS = 896,
  parameter int SECT_W      = 2,
  parameter int MAX_BURST   = 128,
  parameter int LAT         = 2,
  parameter bit WRAP_MODE   = 1'b0,
  parameter int WRAP_LEN    = 4,
  localparam int CNT_W      = $clog2(MAX_BURST + 1),
  localparam int NUM_SECT   = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdReq,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [CNT_W-1:0]    rdCount,
  input  logic [NUM_SECT-1:0] protMask,
  output logic                waitReq,
  output logic                rdValid,
  output logic [WORD_W-1:0]   rdData,
  output logic [1:0]          busyState,
  output logic                readOk
);
  seqStrobe_t strb;
  logic       wordBad;

  flash_seq_ctrl #(
    .CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .WRAP_MODE(WRAP_MODE), .WRAP_LEN(WRAP_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdCount(rdCount),
    .rdValid(rdValid), .wordBad(wordBad), .strb(strb),
    .waitReq(waitReq), .busyState(busyState), .readOk(readOk)
  );

  flash_seq_datapath #(
    .ADDR_W(ADDR_W), .LEGAL_WORDS(LEGAL_WORDS), .SECT_W(SECT_W), .LAT(LAT),
    .WRAP_MODE(WRAP_MODE), .WRAP_LEN(WRAP_LEN)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .protMask(protMask),
    .rdValid(rdValid), .rdData(rdData), .wordBad(wordBad)
  );
endmodule

// File: tb/flash_burst_seq_test.sv
module flash_burst_seq_test;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] protMask = 4'b0;
  logic       reqQ[3];
  logic [9:0] addrQ[3];
  logic [7:0] cntQ[3];
  logic        waitQ[3];
  logic        validQ[3];
  logic [31:0] dataQ[3];
  logic [1:0]  busyQ[3];
  logic        okQ[3];
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_burst_seq uut (
    .clk(clk), .rstN(rstN), .rdReq(reqQ[0]), .rdAddr(addrQ[0]), .rdCount(cntQ[0]),
    .protMask(protMask), .waitReq(waitQ[0]), .rdValid(validQ[0]), .rdData(dataQ[0]),
    .busyState(busyQ[0]), .readOk(okQ[0]));

  flash_burst_seq #(.WRAP_MODE(1'b1), .WRAP_LEN(4)) uutW4 (
    .clk(clk), .rstN(rstN), .rdReq(reqQ[1]), .rdAddr(addrQ[1]), .rdCount(cntQ[1]),
    .protMask(protMask), .waitReq(waitQ[1]), .rdValid(validQ[1]), .rdData(dataQ[1]),
    .busyState(busyQ[1]), .readOk(okQ[1]));

  flash_burst_seq #(.WRAP_MODE(1'b1), .WRAP_LEN(2)) uutW2 (
    .clk(clk), .rstN(rstN), .rdReq(reqQ[2]), .rdAddr(addrQ[2]), .rdCount(cntQ[2]),
    .protMask(protMask), .waitReq(waitQ[2]), .rdValid(validQ[2]), .rdData(dataQ[2]),
    .busyState(busyQ[2]), .readOk(okQ[2]));

  function automatic int wrapLenOf(input int i);
    return (i == 0) ? 0 : ((i == 1) ? 4 : 2);
  endfunction

  function automatic logic [9:0] expAddr(input int i, input logic [9:0] a, input int k);
    int l = wrapLenOf(i);
    if (l == 0) return 10'((int'(a) + k) % 1024);
    return 10'((int'(a) & ~(l - 1)) | ((int'(a) + k) & (l - 1)));
  endfunction

  function automatic bit isBadAddr(input logic [9:0] a);
    return (a >= 10'd896) || protMask[a[9:8]];
  endfunction

  function automatic logic [31:0] expWord(input logic [9:0] a);
    if (isBadAddr(a)) return 32'hFFFF_FFFF;
    return {16'hC0DE ^ {6'b0, a}, {6'b0, a}};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runBurst(input int i, input logic [9:0] a, input logic [7:0] n, input bit hammer);
    int l = wrapLenOf(i);
    bit cmdOk = (n != 0) && (n <= 128) && (l == 0 || int'(n) == l);
    bit anyBad = 1'b0;
    int got = 0;
    int cyc = 0;
    @(negedge clk);
    cmp("R1 idle waitReq low", {31'b0, waitQ[i]}, 32'd0);
    reqQ[i] = 1'b1; addrQ[i] = a; cntQ[i] = n;
    @(negedge clk);
    cmp("R7 busy after accept", {30'b0, busyQ[i]}, 32'd3);
    cmp("R1 waitReq after accept", {31'b0, waitQ[i]}, 32'd1);
    if (hammer) begin
      addrQ[i] = ~a;
    end else begin
      reqQ[i] = 1'b0;
    end
    if (!cmdOk) begin
      cmp("R4 reject no data", {31'b0, validQ[i]}, 32'd0);
      reqQ[i] = 1'b0;
      @(negedge clk);
      cmp("R4 reject busy one cycle", {30'b0, busyQ[i]}, 32'd0);
      cmp("R4 reject readOk", {31'b0, okQ[i]}, 32'd0);
      cmp("R1 reject waitReq released", {31'b0, waitQ[i]}, 32'd0);
      return;
    end
    while (got < int'(n) && cyc < LAT + int'(n) + 4) begin
      if (validQ[i]) begin
        logic [9:0] ea = expAddr(i, a, got);
        if (got == 0) cmp("R5 first word latency", cyc, LAT);
        if (isBadAddr(ea)) anyBad = 1'b1;
        cmp(isBadAddr(ea) ? "R6 bad word all ones" : (l == 0 ? "R2 R5 incr word" : "R3 R5 wrap word"),
            dataQ[i], expWord(ea));
        if (got == int'(n) - 1) begin
          cmp("R7 busy on last word", {30'b0, busyQ[i]}, 32'd3);
          cmp("R1 waitReq on last word", {31'b0, waitQ[i]}, 32'd1);
          reqQ[i] = 1'b0;
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    cmp("R2 word count", got, int'(n));
    cmp("R7 idle after burst", {30'b0, busyQ[i]}, 32'd0);
    cmp("R1 waitReq released", {31'b0, waitQ[i]}, 32'd0);
    cmp("R8 readOk", {31'b0, okQ[i]}, {31'b0, !anyBad});
    reqQ[i] = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3; i++) begin
      reqQ[i] = 1'b0; addrQ[i] = '0; cntQ[i] = '0;
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cmp("R9 reset waitReq", {31'b0, waitQ[i]}, 32'd0);
      cmp("R9 reset rdValid", {31'b0, validQ[i]}, 32'd0);
      cmp("R9 reset busy", {30'b0, busyQ[i]}, 32'd0);
      cmp("R9 reset readOk", {31'b0, okQ[i]}, 32'd0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // directed: incrementing
    protMask = 4'b0000;
    runBurst(0, 10'd0, 8'd1, 1'b0);
    runBurst(0, 10'd5, 8'd128, 1'b0);
    runBurst(0, 10'd1020, 8'd8, 1'b0);
    runBurst(0, 10'd0, 8'd0, 1'b0);
    runBurst(0, 10'd0, 8'd129, 1'b0);
    runBurst(0, 10'd100, 8'd20, 1'b1);
    protMask = 4'b0010;
    runBurst(0, 10'd250, 8'd10, 1'b0);
    runBurst(0, 10'd10, 8'd4, 1'b0);

    // directed: wrapping
    protMask = 4'b0000;
    runBurst(1, 10'd2, 8'd4, 1'b0);
    runBurst(1, 10'd7, 8'd4, 1'b1);
    runBurst(1, 10'd2, 8'd3, 1'b0);
    runBurst(1, 10'd2, 8'd128, 1'b0);
    runBurst(2, 10'd1, 8'd2, 1'b0);
    runBurst(2, 10'd1023, 8'd2, 1'b0);
    runBurst(2, 10'd1, 8'd4, 1'b0);

    // random
    for (int it = 0; it < 40; it++) begin
      int r = int'($urandom % 16);
      logic [7:0] n;
      protMask = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0000;
      if (r == 0) n = 8'd0;
      else if (r == 1) n = 8'(129 + $urandom % 100);
      else n = 8'(1 + $urandom % 128);
      runBurst(0, 10'($urandom), n, ($urandom % 5) == 0);
    end
    for (int it = 0; it < 30; it++) begin
      int w = 1 + int'($urandom % 2);
      logic [7:0] n = ($urandom % 6 == 0) ? 8'(1 + $urandom % 5) : 8'(wrapLenOf(w));
      protMask = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0000;
      runBurst(w, 10'($urandom), n, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule